// File: doc/BRIEF.md
# Significance Map Bin Sequencer

This block steers the decoding of the significance map of one residual block. The significance flags and end-of-block flags are handled as one interleaved bin string. The flag at even index 2i asks whether scan position i holds a nonzero coefficient. The flag at odd index 2i+1 asks whether that coefficient is the final nonzero one in the block. Because of this, the whole map is one syntax element, and no context switch to another element is needed between the two flag kinds. The block does no context index arithmetic and no arithmetic decoding. The surrounding decoder uses the bin index and flag type that this block presents to choose the context, decodes one or two bins, and returns their values.

Each accepted beat carries up to `LANES` bin values. The bins are applied in order through a chain of combinational step stages. The block also presents the index the second bin of a pair would have for either value of the first bin, so that the decoder can fetch both candidate contexts ahead of time. When the map completes, a one-cycle done pulse is raised. The significance bitmap then stays held until the next start. Only its low `num_coeff_i` bits are meaningful.

Top module: `sigmap_seq`

## Requirements
- R1: A start pulse clears the bitmap and, when the coefficient count is 2 or more, makes the block ready on the next cycle with bin index 0, flag type significance (cur_last_o = 0) and scan position 0. A start overrides any block in progress.
- R2: While ready, cur_idx_o equals 2 × scan_pos_o + cur_last_o. A significance flag sits at an even index and an end flag at an odd index.
- R3: An accepted significance flag of 0 moves to the significance flag of the next position, so the index advances by 2.
- R4: An accepted significance flag of 1 sets the bitmap bit of the current position and moves to the end flag of the same position, so the index advances by 1.
- R5: An accepted end flag of 0 moves to the significance flag of the next position, so the index advances by 1.
- R6: An accepted end flag of 1 completes the map. done_o pulses on the next cycle and bin_ready_o falls.
- R7: When the scan position would advance to count−1, the map completes. Bit count−1 of the bitmap is set and no flag is requested for that position.
- R8: A beat with bin_cnt_i = 2 applies bit 0 of bin_val_i first and bit 1 second. sec_idx_zero_o (the second bin's index if the first is 0) is the current index plus 2 after a significance flag and plus 1 after an end flag. sec_idx_one_o is the current index plus 1.
- R9: If the map completes on the first bin of a pair, the second bin is discarded and does not alter the bitmap.
- R10: A start with a coefficient count of 0 or 1 completes at once: done_o pulses on the next cycle, and the bitmap is 1 for a count of 1 and 0 for a count of 0.
- R11: done_o is high for exactly one cycle per block. While the block is not ready, valid beats have no effect and the bitmap holds its value.
- R12: After reset, bin_ready_o and done_o are 0 and the bitmap is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new block |
| num_coeff_i | input | $clog2(MAXC+1) | Coefficient count of the block, sampled at start |
| bin_valid_i | input | 1 | Decoded bins are present |
| bin_cnt_i | input | $clog2(LANES+1) | Number of bins in the beat |
| bin_val_i | input | LANES | Bin values, bit 0 first |
| bin_ready_o | output | 1 | Block accepts bins |
| cur_idx_o | output | $clog2(2*MAXC) | Index of the next bin |
| cur_last_o | output | 1 | Flag type of the next bin: 0 significance, 1 end |
| sec_idx_zero_o | output | $clog2(2*MAXC) | Second-bin index if the first bin is 0 |
| sec_idx_one_o | output | $clog2(2*MAXC) | Second-bin index if the first bin is 1 |
| scan_pos_o | output | $clog2(MAXC) | Current scan position |
| done_o | output | 1 | One-cycle pulse on completion |
| sig_map_o | output | MAXC | Significance bitmap |

## Verification
The bench builds the block with MAXC = 16 and LANES = 2. It sweeps every coefficient count from 0 to 16 under several bin patterns: all zeros, which runs to the final-position rule; alternating significance 1 and end 0, which fills the bitmap; all ones, which ends at position 0; and pseudo-random mixes of single beats and pairs. With the small map, every position and every way a pair can straddle a completion is reached, including a final position landed on by the first bin of a pair. The expected index, position, bitmap and done timing come from a stepwise arithmetic model of the flag transitions.

// File: rtl/sm_pkg.sv
package sm_pkg;
   typedef enum logic {
      FLAG_SIG  = 1'b0,
      FLAG_LAST = 1'b1
   } flag_e;
endpackage

// File: rtl/sm_step.sv
module sm_step #(
   parameter int MAXC = 64,
   localparam int PW = $clog2(MAXC),
   localparam int NW = $clog2(MAXC + 1)
) (
   input  logic            en_i,
   input  logic [PW-1:0]   pos_i,
   input  logic            last_i,
   input  logic            val_i,
   input  logic [NW-1:0]   num_i,
   output logic [PW-1:0]   pos_o,
   output logic            last_o,
   output logic            fin_o,
   output logic [MAXC-1:0] set_o
);
   import sm_pkg::*;

   logic [NW-1:0] nxt;
   logic [NW-1:0] tail;
   logic          at_tail;

   assign nxt     = NW'(pos_i) + NW'(1);
   assign tail    = num_i - NW'(1);
   assign at_tail = (nxt == tail);

   always_comb begin
      pos_o  = pos_i;
      last_o = last_i;
      fin_o  = 1'b0;
      set_o  = '0;
      if (en_i) begin
         if (flag_e'(last_i) == FLAG_SIG && val_i) begin
            last_o       = 1'b1;
            set_o[pos_i] = 1'b1;
         end else if (flag_e'(last_i) == FLAG_LAST && val_i) begin
            fin_o = 1'b1;
         end else begin
            pos_o  = nxt[PW-1:0];
            last_o = 1'b0;
            if (at_tail) begin
               fin_o             = 1'b1;
               set_o[nxt[PW-1:0]] = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sm_index.sv
module sm_index #(
   parameter int MAXC = 64,
   localparam int PW = $clog2(MAXC),
   localparam int IW = $clog2(2 * MAXC)
) (
   input  logic [PW-1:0] pos_i,
   input  logic          last_i,
   output logic [IW-1:0] idx_o,
   output logic [IW-1:0] sec_zero_o,
   output logic [IW-1:0] sec_one_o
);
   assign idx_o      = {pos_i, last_i};
   assign sec_zero_o = idx_o + (last_i ? IW'(1) : IW'(2));
   assign sec_one_o  = idx_o + IW'(1);
endmodule

// File: rtl/sigmap_seq.sv
module sigmap_seq #(
   parameter int MAXC  = 64,
   parameter int LANES = 2,
   localparam int PW = $clog2(MAXC),
   localparam int NW = $clog2(MAXC + 1),
   localparam int IW = $clog2(2 * MAXC),
   localparam int CW = $clog2(LANES + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [NW-1:0]   num_coeff_i,
   input  logic            bin_valid_i,
   input  logic [CW-1:0]   bin_cnt_i,
   input  logic [LANES-1:0] bin_val_i,
   output logic            bin_ready_o,
   output logic [IW-1:0]   cur_idx_o,
   output logic            cur_last_o,
   output logic [IW-1:0]   sec_idx_zero_o,
   output logic [IW-1:0]   sec_idx_one_o,
   output logic [PW-1:0]   scan_pos_o,
   output logic            done_o,
   output logic [MAXC-1:0] sig_map_o
);
   generate
      if (MAXC < 2) begin : g_bad_maxc
         $error("sigmap_seq: MAXC must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("sigmap_seq: LANES must be at least 1");
      end
   endgenerate

   logic            busy_q;
   logic [PW-1:0]   pos_q;
   logic            last_q;
   logic [NW-1:0]   num_q;
   logic [MAXC-1:0] map_q;
   logic            done_q;
   logic            beat;

   logic [PW-1:0]   lpos  [0:LANES];
   logic            llast [0:LANES];
   logic            lfin  [0:LANES];
   logic [MAXC-1:0] lset  [0:LANES-1];
   logic [MAXC-1:0] set_all;

   assign beat    = busy_q && bin_valid_i && !start_i;
   assign lpos[0]  = pos_q;
   assign llast[0] = last_q;
   assign lfin[0]  = 1'b0;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic fin_k;
      logic en_k;
      assign en_k = beat && (CW'(k) < bin_cnt_i) && !lfin[k];
      sm_step #(.MAXC(MAXC)) i_step (
         .en_i   (en_k),
         .pos_i  (lpos[k]),
         .last_i (llast[k]),
         .val_i  (bin_val_i[k]),
         .num_i  (num_q),
         .pos_o  (lpos[k+1]),
         .last_o (llast[k+1]),
         .fin_o  (fin_k),
         .set_o  (lset[k])
      );
      assign lfin[k+1] = lfin[k] || fin_k;
   end

   always_comb begin
      set_all = '0;
      for (int k = 0; k < LANES; k++) set_all = set_all | lset[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pos_q  <= '0;
         last_q <= 1'b0;
         num_q  <= '0;
         map_q  <= '0;
         done_q <= 1'b0;
      end else if (start_i) begin
         busy_q <= (num_coeff_i > NW'(1));
         pos_q  <= '0;
         last_q <= 1'b0;
         num_q  <= num_coeff_i;
         map_q  <= MAXC'(num_coeff_i == NW'(1));
         done_q <= (num_coeff_i <= NW'(1));
      end else if (beat) begin
         busy_q <= !lfin[LANES];
         pos_q  <= lpos[LANES];
         last_q <= llast[LANES];
         map_q  <= map_q | set_all;
         done_q <= lfin[LANES];
      end else begin
         done_q <= 1'b0;
      end
   end

   sm_index #(.MAXC(MAXC)) i_index (
      .pos_i      (pos_q),
      .last_i     (last_q),
      .idx_o      (cur_idx_o),
      .sec_zero_o (sec_idx_zero_o),
      .sec_one_o  (sec_idx_one_o)
   );

   assign bin_ready_o = busy_q;
   assign cur_last_o  = last_q;
   assign scan_pos_o  = pos_q;
   assign done_o      = done_q;
   assign sig_map_o   = map_q;

   // R3: a lone significance 0 steps the index by two unless it finished the map
   p_sig0_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bin_ready_o && bin_valid_i && !start_i && bin_cnt_i == CW'(1) && !cur_last_o && !bin_val_i[0])
      |=> (done_o || cur_idx_o == $past(cur_idx_o) + IW'(2)));

   // R4: a lone significance 1 moves to the end flag of the same position
   p_sig1_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bin_ready_o && bin_valid_i && !start_i && bin_cnt_i == CW'(1) && !cur_last_o && bin_val_i[0])
      |=> (cur_last_o && $stable(scan_pos_o) && bin_ready_o));

   // R6: completion drops ready
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !bin_ready_o);

   // R11: done is a single-cycle pulse
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);

   // R11: bitmap holds while idle
   p_map_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bin_ready_o && !start_i) |=> $stable(sig_map_o));
endmodule

// File: tb/test_sigmap_seq.sv
module test_sigmap_seq;
   localparam int MAXC  = 16;
   localparam int LANES = 2;
   localparam int PW = $clog2(MAXC);
   localparam int NW = $clog2(MAXC + 1);
   localparam int IW = $clog2(2 * MAXC);
   localparam int CW = $clog2(LANES + 1);
   localparam time CLK_PERIOD = 10ns;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [NW-1:0]   num_coeff_i = '0;
   logic            bin_valid_i = 1'b0;
   logic [CW-1:0]   bin_cnt_i = '0;
   logic [LANES-1:0] bin_val_i = '0;
   logic            bin_ready_o;
   logic [IW-1:0]   cur_idx_o;
   logic            cur_last_o;
   logic [IW-1:0]   sec_idx_zero_o;
   logic [IW-1:0]   sec_idx_one_o;
   logic [PW-1:0]   scan_pos_o;
   logic            done_o;
   logic [MAXC-1:0] sig_map_o;

   int n_cmp = 0;
   int n_bad = 0;

   int              m_num;
   int              m_pos;
   logic            m_last;
   logic            m_fin;
   logic            m_done;
   logic [MAXC-1:0] m_map;
   logic [15:0]     lf = 16'hACE1;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sigmap_seq #(.MAXC(MAXC), .LANES(LANES)) i_sigmap_seq (
      .clk, .rst_n, .start_i, .num_coeff_i, .bin_valid_i, .bin_cnt_i, .bin_val_i,
      .bin_ready_o, .cur_idx_o, .cur_last_o, .sec_idx_zero_o, .sec_idx_one_o,
      .scan_pos_o, .done_o, .sig_map_o
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step_lf();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
   endtask

   // model of one bin, per R3, R4, R5, R6, R7
   task automatic model_bin(input logic v);
      if (!m_last && v) begin
         m_last = 1'b1;
         m_map[m_pos] = 1'b1;
      end else if (m_last && v) begin
         m_fin = 1'b1;
      end else begin
         m_pos++;
         m_last = 1'b0;
         if (m_pos == m_num - 1) begin
            m_fin = 1'b1;
            m_map[m_pos] = 1'b1;
         end
      end
   endtask

   task automatic compare(input string tag);
      chk(bin_ready_o == !m_fin, {tag, " R6 ready"}, bin_ready_o, !m_fin);
      chk(done_o == m_done, {tag, " R11 done"}, done_o, m_done);
      chk(sig_map_o == m_map, {tag, " R7 map"}, sig_map_o, m_map);
      if (!m_fin) begin
         chk(cur_idx_o == IW'(2 * m_pos + m_last), {tag, " R2 idx"}, cur_idx_o, 2 * m_pos + m_last);
         chk(scan_pos_o == PW'(m_pos), {tag, " R2 pos"}, scan_pos_o, m_pos);
         chk(sec_idx_zero_o == IW'(2 * m_pos + m_last + (m_last ? 1 : 2)), {tag, " R8 sec0"},
             sec_idx_zero_o, 2 * m_pos + m_last + (m_last ? 1 : 2));
         chk(sec_idx_one_o == IW'(2 * m_pos + m_last + 1), {tag, " R8 sec1"},
             sec_idx_one_o, 2 * m_pos + m_last + 1);
      end
   endtask

   task automatic do_start(input int num);
      start_i = 1'b1;
      num_coeff_i = NW'(num);
      @(posedge clk);
      m_num = num; m_pos = 0; m_last = 1'b0;
      m_map = (num == 1) ? MAXC'(1) : '0;
      m_fin = (num <= 1); m_done = m_fin;
      @(negedge clk);
      start_i = 1'b0;
      compare("R1 R10 start");
   endtask

   // R8 R9: pairs apply bit 0 then bit 1, stop at completion
   task automatic send(input int cnt, input logic [LANES-1:0] v);
      bin_valid_i = 1'b1;
      bin_cnt_i = CW'(cnt);
      bin_val_i = v;
      @(posedge clk);
      m_done = 1'b0;
      if (!m_fin) begin
         for (int k = 0; k < cnt; k++) if (!m_fin) model_bin(v[k]);
         m_done = m_fin;
      end
      @(negedge clk);
      bin_valid_i = 1'b0;
      compare(cnt == 2 ? "R8 R9 pair" : "R3 R4 R5 single");
   endtask

   task automatic run_block(input int num, input int mode);
      logic [LANES-1:0] v;
      int cnt;
      do_start(num);
      while (!m_fin) begin
         step_lf();
         cnt = lf[0] ? 2 : 1;
         case (mode)
            0: v = '0;
            1: v = m_last ? 2'b10 : 2'b01;
            2: v = '1;
            default: v = {lf[5] & lf[7], lf[3] & lf[9]};
         endcase
         send(cnt, v);
      end
      // R11: beats while idle are ignored
      send(2, 2'b11);
      chk(!done_o, "R11 idle beat no done", done_o, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(bin_ready_o == 1'b0, "R12 reset ready", bin_ready_o, 0);
      chk(done_o == 1'b0, "R12 reset done", done_o, 0);
      chk(sig_map_o == '0, "R12 reset map", sig_map_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      m_num = 0; m_pos = 0; m_last = 0; m_fin = 1; m_done = 0; m_map = '0;
      // R1: restart overrides a block in progress
      do_start(16);
      send(1, 2'b01);
      send(1, 2'b00);
      do_start(16);
      for (int num = 0; num <= MAXC; num++) begin
         for (int mode = 0; mode < 7; mode++) run_block(num, mode);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule